// File: doc/BRIEF.md
# Throttled Prefetch Line Buffer

A small fully associative store that sits between a prefetching engine and the CPU-side cache. The engine pushes cache lines into it, each labelled with its line tag. The cache looks up a tag, and a hit returns the line and releases the slot. Each slot is either occupied or free. A slot becomes occupied when the engine fills it and becomes free again when the CPU consumes it.

The occupancy state limits how far ahead of the CPU the engine can run. When every slot is occupied and none has been consumed, the block raises a stall output to the engine. Further fills for new tags are refused rather than overwriting lines that have not been used. A single consumption frees a slot and drops the stall, so the engine resumes.

Top module: `pushbuf_throttle`

## Requirements
- R1: After reset every slot is free, `stall` is low and `rsp_valid` is low.
- R2: A fill whose tag is not present, presented while some slot is free, stores the line. A later lookup of that tag returns the stored line.
- R3: A lookup that hits produces `rsp_valid`=1, `rsp_hit`=1 and the stored line on `rsp_line` in the next cycle. The slot is freed at that same edge, so a second lookup of the tag misses.
- R4: A lookup that misses produces `rsp_valid`=1, `rsp_hit`=0 and `rsp_line`=0 in the next cycle. `rsp_valid` is low in the cycle after a cycle with no lookup.
- R5: A fill whose tag is already present overwrites that slot's line in place and takes no additional slot. This holds even when every slot is occupied.
- R6: `stall` is a registered output. It is high in the cycle after an edge exactly when no slot is free after that edge.
- R7: A fill for an absent tag while no slot is free is ignored. A later lookup of that tag misses, and the stored lines are unchanged.
- R8: A consumption while `stall` is high drops `stall` in the next cycle.
- R9: When a fill and a lookup name the same present tag in one cycle, the lookup returns the line held before the fill, and the slot ends up free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Engine pushes a line this cycle |
| fill_tag | input | TAG_W | Tag of the pushed line |
| fill_line | input | LINE_W | Pushed line data |
| look_valid | input | 1 | CPU lookup this cycle |
| look_tag | input | TAG_W | Tag being looked up |
| rsp_valid | output | 1 | Lookup response present (one cycle after the lookup) |
| rsp_hit | output | 1 | Response is a hit |
| rsp_line | output | LINE_W | Hit line, zero on a miss |
| stall | output | 1 | Engine must suspend; no slot is free |

## Verification
The bench builds the block with 4 slots, 8-bit tags and 16-bit lines. With only four slots, a handful of fills fills the buffer, so the stall, refusal and resume behaviour is exercised many times. Random tags drawn from only eight values make in-place overwrites, repeated consumption and same-cycle fill-and-consume collisions frequent. The directed opening walks through the filled buffer, the refused fill, the overwrite in place and the collision on a known sequence before the random phase.

// File: rtl/pushbuf_throttle.sv
module pushbuf_throttle #(
  parameter int ENTRIES = 32,
  parameter int TAG_W   = 26,
  parameter int LINE_W  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              look_valid,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [LINE_W-1:0] rsp_line,
  output logic              stall
);

  logic [ENTRIES-1:0] occ, occ_nxt;
  logic [ENTRIES-1:0] fill_match, look_match, free_pick, wr_en, look_fire;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [LINE_W-1:0]  line_q [ENTRIES];
  logic [LINE_W-1:0]  sel_line;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    assign fill_match[i] = occ[i] && (tag_q[i] == fill_tag);
    assign look_match[i] = occ[i] && (tag_q[i] == look_tag);

    always_ff @(posedge clk) begin
      if (wr_en[i]) begin
        tag_q[i]  <= fill_tag;
        line_q[i] <= fill_line;
      end
    end
  end

  always_comb begin
    free_pick = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        free_pick    = '0;
        free_pick[i] = 1'b1;
      end
    end
  end

  assign wr_en     = !fill_valid ? '0 : (|fill_match) ? fill_match : free_pick;
  assign look_fire = look_valid ? look_match : '0;
  assign occ_nxt   = (occ | wr_en) & ~look_fire;

  always_comb begin
    sel_line = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (look_fire[i]) sel_line = sel_line | line_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ       <= '0;
      stall     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_line  <= '0;
    end else begin
      occ       <= occ_nxt;
      stall     <= &occ_nxt;
      rsp_valid <= look_valid;
      rsp_hit   <= |look_fire;
      rsp_line  <= sel_line;
    end
  end

  // R3
  look_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_match));

  // R4
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_line == '0));

  // R6
  stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ($countones(occ) == ENTRIES));

  // R7
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && stall && !(|fill_match) && !look_valid) |=> $stable(occ));

  // R2
  grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !stall && !(|fill_match) && !(look_valid && |look_match))
      |=> ($countones(occ) == $past($countones(occ)) + 1));

  // R8
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && look_valid && |look_match) |=> !stall);

endmodule

// File: tb/pushbuf_throttle_test.sv
`timescale 1ns/1ps
module pushbuf_throttle_test;
  localparam int N  = 4;
  localparam int TW = 8;
  localparam int LW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fill_valid = 1'b0, look_valid = 1'b0;
  logic [TW-1:0] fill_tag = '0, look_tag = '0;
  logic [LW-1:0] fill_line = '0;
  logic rsp_valid, rsp_hit, stall;
  logic [LW-1:0] rsp_line;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pushbuf_throttle #(.ENTRIES(N), .TAG_W(TW), .LINE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_line(fill_line),
    .look_valid(look_valid), .look_tag(look_tag),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_line(rsp_line), .stall(stall));

  // reference model
  bit          m_occ [N];
  logic [TW-1:0] m_tag [N];
  logic [LW-1:0] m_data[N];
  bit e_valid, e_hit, e_stall;
  logic [LW-1:0] e_line;

  always @(posedge clk) begin
    int h, m, a;
    logic [LW-1:0] old;
    bit full;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_occ[i] = 0;
      e_valid = 0; e_hit = 0; e_line = '0; e_stall = 0;
    end else begin
      h = -1; m = -1; a = -1;
      for (int i = 0; i < N; i++) begin
        if (m_occ[i] && m_tag[i] == look_tag) h = i;
        if (m_occ[i] && m_tag[i] == fill_tag) m = i;
      end
      for (int i = N - 1; i >= 0; i--) if (!m_occ[i]) a = i;
      old = (h >= 0) ? m_data[h] : '0;
      if (fill_valid) begin
        if (m >= 0) m_data[m] = fill_line;
        else if (a >= 0) begin
          m_occ[a] = 1; m_tag[a] = fill_tag; m_data[a] = fill_line;
        end
      end
      if (look_valid && h >= 0) m_occ[h] = 0;
      e_valid = look_valid;
      e_hit   = look_valid && (h >= 0);
      e_line  = e_hit ? old : '0;
      full = 1;
      for (int i = 0; i < N; i++) if (!m_occ[i]) full = 0;
      e_stall = full;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 rsp_valid", 64'(rsp_valid), 64'(e_valid));
      chk("R3 rsp_hit",   64'(rsp_hit),   64'(e_hit));
      chk("R2 rsp_line",  64'(rsp_line),  64'(e_line));
      chk("R6 stall",     64'(stall),     64'(e_stall));
    end
  end

  task automatic step(input bit fv, input int ft, input int fl, input bit lv, input int lt);
    fill_valid = fv; fill_tag = TW'(ft); fill_line = LW'(fl);
    look_valid = lv; look_tag = TW'(lt);
    @(posedge clk); @(negedge clk);
    fill_valid = 0; look_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 stall", 64'(stall), 0);
    chk("R1 rsp_valid", 64'(rsp_valid), 0);
    step(1, 1, 16'h1111, 0, 0);
    step(1, 2, 16'h2020, 0, 0);
    step(1, 3, 16'h3333, 0, 0);
    chk("R6 not full", 64'(stall), 0);
    step(1, 4, 16'h4444, 0, 0);
    chk("R6 full", 64'(stall), 1);
    step(1, 5, 16'h5555, 0, 0);          // R7 refused
    chk("R7 still stalled", 64'(stall), 1);
    step(1, 2, 16'h2222, 0, 0);          // R5 overwrite while full
    chk("R5 no slot taken", 64'(stall), 1);
    step(0, 0, 0, 1, 5);
    chk("R7 refused tag misses", 64'(rsp_hit), 0);
    chk("R4 miss line zero", 64'(rsp_line), 0);
    chk("R4 miss valid", 64'(rsp_valid), 1);
    step(0, 0, 0, 1, 2);
    chk("R5 overwritten line", 64'(rsp_line), 64'h2222);
    chk("R3 hit", 64'(rsp_hit), 1);
    chk("R8 resumed", 64'(stall), 0);
    step(0, 0, 0, 1, 2);
    chk("R3 consumed slot misses", 64'(rsp_hit), 0);
    step(1, 6, 16'h6666, 0, 0);
    chk("R6 full again", 64'(stall), 1);
    step(1, 1, 16'h9999, 1, 1);
    chk("R9 old line returned", 64'(rsp_line), 64'h1111);
    chk("R9 slot freed", 64'(stall), 0);
    step(0, 0, 0, 1, 1);
    chk("R9 tag gone", 64'(rsp_hit), 0);
    step(0, 0, 0, 1, 4);
    chk("R2 stored line", 64'(rsp_line), 64'h4444);
    for (int k = 0; k < 3000; k++)
      step(($urandom % 3) != 0, int'($urandom % 8), int'($urandom % 65536),
           ($urandom % 2) == 1, int'($urandom % 8));
    for (int t = 0; t < 8; t++) step(0, 0, 0, 1, t);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule